// File: doc/BRIEF.md
# Ethernet destination address filter

This block sits at the front of a receive path and decides, from the first six bytes of an incoming frame, whether the frame is kept. Those six bytes are the destination address. They arrive one per cycle on a byte stream that may pause between bytes. A one-cycle frame-start pulse opens each frame. Three mode inputs enable promiscuous reception, broadcast reception and multicast reception. The block also receives the station's own 48-bit address and a 64-bit multicast hash table.

The address is classified as it streams in. An all-ones address is broadcast. Any other address whose first byte has bit 0 set is multicast. Everything else is unicast. A CRC-32 of the address is accumulated byte by byte, and its top six bits select one bit of the hash table. Once the sixth byte has been taken, the block issues a single verdict, accept or reject, together with a flag that marks a group (multicast or broadcast) address. The verdict is held until the next frame start. A rejected frame is simply dropped by the downstream logic. No error is raised for it.

Top module: `dest_addr_filter`

## Requirements
- R1: When acceptAll is high at the sixth byte, the frame is accepted whatever its address.
- R2: A destination of six 0xFF bytes is broadcast. Without acceptAll, it is accepted exactly when acceptBcast is high. The multicast enable and the hash table have no effect on it.
- R3: A non-broadcast destination whose first received byte has bit 0 set is multicast. Without acceptAll, it is accepted only when acceptMcast is high and the selected hash-table bit is 1.
- R4: The hash index is bits 31..26 of a CRC-32 over the six bytes in arrival order. The CRC uses polynomial 0x04C11DB7 and starts from all ones. Each byte is fed bit 0 first, and there is no final inversion. The index selects hashTable[index], which is bit (index mod 8) of table byte (index / 8), where table byte k sits at hashTable[8k+7:8k].
- R5: A unicast destination, with acceptAll low, is accepted only when every received byte k (k = 0 first) equals stationAddr[8k+7:8k]. The mode enables do not affect it.
- R6: A frame that is not accepted produces reject high and accept low, and nothing else.
- R7: decisionValid rises in the cycle after the sixth byte is presented with byteValid, and not earlier. While it is high, exactly one of accept and reject is high. Idle cycles between bytes are allowed.
- R8: Once decisionValid is high, the verdict and groupAddr stay unchanged until the next frameStart. Further bytes and changes to the mode inputs do not alter them.
- R9: A frameStart pulse clears decisionValid in the next cycle. A byte presented in the same cycle as frameStart is not counted as part of the address.
- R10: After reset, decisionValid, accept, reject and groupAddr are all low.
- R11: While decisionValid is high, groupAddr equals bit 0 of the first address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frameStart | input | 1 | One-cycle pulse that opens a new frame |
| byteValid | input | 1 | byteData carries an address byte |
| byteData | input | 8 | Address byte, first byte of the address first |
| acceptAll | input | 1 | Promiscuous mode enable |
| acceptBcast | input | 1 | Broadcast reception enable |
| acceptMcast | input | 1 | Multicast reception enable (subject to hash hit) |
| stationAddr | input | 48 | Station address, byte k at bits 8k+7..8k |
| hashTable | input | 64 | Multicast hash table, bit n selected by index n |
| decisionValid | output | 1 | Verdict is available and held |
| accept | output | 1 | Frame is to be kept |
| reject | output | 1 | Frame is to be dropped silently |
| groupAddr | output | 1 | Destination is a group address |

## Verification
A corrupted CRC register or a wrong byte index leaves no trace until the sixth byte. It then shows up in that single verdict as a flipped accept/reject on multicast or unicast frames, so every check samples the cycle right after that byte. A stuck byte counter shows up as decisionValid rising early, rising late, or never rising. Vectors that pair a hash table holding only the expected bit with one holding every bit except it expose any error in the index. A frame start that overlaps a byte, followed by a station-address frame, exposes an off-by-one in how bytes are counted.

// File: rtl/dest_filter_pkg.sv
package dest_filter_pkg;

  localparam int DA_BYTES   = 6;
  localparam int IDX_W      = $clog2(DA_BYTES);
  localparam int HASH_BITS  = 6;
  localparam int TABLE_W    = 1 << HASH_BITS;
  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

  typedef struct packed {
    logic             clear;
    logic             take;
    logic             last;
    logic [IDX_W-1:0] idx;
  } filt_strobe_t;

  // One byte into the running CRC, bit 0 of the byte first.
  function automatic logic [31:0] crcStep8(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[31] ^ b[i]) r = (r << 1) ^ CRC_POLY;
      else              r = r << 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/dest_filter_ctrl.sv
module dest_filter_ctrl
  import dest_filter_pkg::*;
#(
  parameter int NBYTES = DA_BYTES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frameStart,
  input  logic         byteValid,
  output filt_strobe_t strb,
  output logic         decisionValid
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_COLLECT, ST_DONE} ctrl_state_t;

  ctrl_state_t      stateQ;
  logic [IDX_W-1:0] idxQ;

  always_comb begin
    strb.clear = frameStart;
    strb.take  = byteValid && !frameStart && (stateQ == ST_COLLECT);
    strb.last  = (idxQ == LAST_IDX);
    strb.idx   = idxQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ        <= ST_IDLE;
      idxQ          <= '0;
      decisionValid <= 1'b0;
    end else if (frameStart) begin
      stateQ        <= ST_COLLECT;
      idxQ          <= '0;
      decisionValid <= 1'b0;
    end else if (strb.take) begin
      if (strb.last) begin
        stateQ        <= ST_DONE;
        decisionValid <= 1'b1;
      end else begin
        idxQ <= idxQ + 1'b1;
      end
    end
  end

  // R9: a frame start always withdraws the previous verdict
  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    frameStart |=> !decisionValid);

  // R8: verdict stays up until the next frame start
  a_r8_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    (decisionValid && !frameStart) |=> decisionValid);

  // R7: byte index never runs past the address length
  a_r7_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idxQ <= LAST_IDX);

endmodule

// File: rtl/dest_filter_dp.sv
module dest_filter_dp
  import dest_filter_pkg::*;
#(
  parameter int NBYTES = DA_BYTES,
  parameter int HBITS  = HASH_BITS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  filt_strobe_t          strb,
  input  logic [7:0]            byteData,
  input  logic                  acceptAll,
  input  logic                  acceptBcast,
  input  logic                  acceptMcast,
  input  logic [NBYTES*8-1:0]   stationAddr,
  input  logic [(1<<HBITS)-1:0] hashTable,
  output logic                  acceptQ,
  output logic                  rejectQ,
  output logic                  groupQ
);

  logic [31:0]      crcQ;
  logic             allOnesQ;
  logic             matchQ;

  logic [31:0]      crcNext;
  logic             allOnesNext;
  logic             matchNext;
  logic             groupNext;
  logic [7:0]       stationByte;
  logic [HBITS-1:0] hashIdx;
  logic             hashHit;
  logic             verdict;

  always_comb begin
    stationByte = stationAddr[strb.idx*8 +: 8];
    crcNext     = crcStep8(crcQ, byteData);
    allOnesNext = allOnesQ && (byteData == 8'hFF);
    matchNext   = matchQ && (byteData == stationByte);
    groupNext   = (strb.idx == '0) ? byteData[0] : groupQ;
    hashIdx     = crcNext[31 -: HBITS];
    hashHit     = hashTable[hashIdx];
    if (acceptAll)        verdict = 1'b1;
    else if (allOnesNext) verdict = acceptBcast;
    else if (groupNext)   verdict = acceptMcast && hashHit;
    else                  verdict = matchNext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crcQ     <= CRC_SEED;
      allOnesQ <= 1'b1;
      matchQ   <= 1'b1;
      groupQ   <= 1'b0;
      acceptQ  <= 1'b0;
      rejectQ  <= 1'b0;
    end else if (strb.clear) begin
      crcQ     <= CRC_SEED;
      allOnesQ <= 1'b1;
      matchQ   <= 1'b1;
      groupQ   <= 1'b0;
      acceptQ  <= 1'b0;
      rejectQ  <= 1'b0;
    end else if (strb.take) begin
      crcQ     <= crcNext;
      allOnesQ <= allOnesNext;
      matchQ   <= matchNext;
      groupQ   <= groupNext;
      if (strb.last) begin
        acceptQ <= verdict;
        rejectQ <= !verdict;
      end
    end
  end

  // R1: promiscuous mode at the final byte forces acceptance
  a_r1_promisc_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.take && strb.last && acceptAll) |=> acceptQ);

  // R2: broadcast with the broadcast enable low and promiscuous low is refused
  a_r2_bcast_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.take && strb.last && allOnesQ && byteData == 8'hFF && !acceptAll && !acceptBcast)
      |=> rejectQ);

endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import dest_filter_pkg::*;
#(
  parameter int NBYTES = DA_BYTES,
  parameter int HBITS  = HASH_BITS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frameStart,
  input  logic                  byteValid,
  input  logic [7:0]            byteData,
  input  logic                  acceptAll,
  input  logic                  acceptBcast,
  input  logic                  acceptMcast,
  input  logic [NBYTES*8-1:0]   stationAddr,
  input  logic [(1<<HBITS)-1:0] hashTable,
  output logic                  decisionValid,
  output logic                  accept,
  output logic                  reject,
  output logic                  groupAddr
);

  filt_strobe_t strb;
  logic         groupQ;

  dest_filter_ctrl #(.NBYTES(NBYTES)) ctrl_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .frameStart    (frameStart),
    .byteValid     (byteValid),
    .strb          (strb),
    .decisionValid (decisionValid)
  );

  dest_filter_dp #(.NBYTES(NBYTES), .HBITS(HBITS)) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .byteData    (byteData),
    .acceptAll   (acceptAll),
    .acceptBcast (acceptBcast),
    .acceptMcast (acceptMcast),
    .stationAddr (stationAddr),
    .hashTable   (hashTable),
    .acceptQ     (accept),
    .rejectQ     (reject),
    .groupQ      (groupQ)
  );

  assign groupAddr = decisionValid && groupQ;

  // R7: a held verdict is exactly one of accept or reject
  a_r7_verdict_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    decisionValid |-> (accept != reject));

  // R10: no verdict lines while no decision is held
  a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !decisionValid |-> (!accept && !reject));

  // R8: verdict and group flag frozen until the next frame start
  a_r8_verdict_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (decisionValid && !frameStart) |=> ($stable(accept) && $stable(groupAddr)));

endmodule

// File: tb/dest_addr_filter_tb_top.sv
`timescale 1ns/1ps
module dest_addr_filter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frameStart = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = 8'h00;
  logic        acceptAll = 1'b0;
  logic        acceptBcast = 1'b0;
  logic        acceptMcast = 1'b0;
  logic [47:0] stationAddr = 48'h5544_3322_1102;
  logic [63:0] hashTable = 64'h0;
  logic        decisionValid, accept, reject, groupAddr;

  int applied = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dest_addr_filter dut_i (
    .clk(clk), .rst_n(rst_n), .frameStart(frameStart), .byteValid(byteValid),
    .byteData(byteData), .acceptAll(acceptAll), .acceptBcast(acceptBcast),
    .acceptMcast(acceptMcast), .stationAddr(stationAddr), .hashTable(hashTable),
    .decisionValid(decisionValid), .accept(accept), .reject(reject),
    .groupAddr(groupAddr)
  );

  // Fields: {all, bcast, mcast, dest[47:0], tableMode[1:0], expAccept, expGroup}
  // tableMode: 0 empty, 1 only the hashed bit, 2 all but the hashed bit, 3 full
  localparam int NVEC = 16;
  localparam logic [54:0] VEC [NVEC] = '{
    {3'b000, 48'h5544_3322_1102, 2'd0, 1'b1, 1'b0},  // R5 exact match
    {3'b000, 48'h5644_3322_1102, 2'd0, 1'b0, 1'b0},  // R5 last byte differs
    {3'b000, 48'h5544_3322_1100, 2'd0, 1'b0, 1'b0},  // R5 first byte differs
    {3'b010, 48'hFFFF_FFFF_FFFF, 2'd0, 1'b1, 1'b1},  // R2 enabled
    {3'b000, 48'hFFFF_FFFF_FFFF, 2'd3, 1'b0, 1'b1},  // R2 disabled
    {3'b001, 48'hFFFF_FFFF_FFFF, 2'd3, 1'b0, 1'b1},  // R2 mcast enable no help
    {3'b100, 48'h0123_4567_89AA, 2'd0, 1'b1, 1'b0},  // R1 foreign unicast
    {3'b100, 48'hFFFF_FFFF_FFFF, 2'd0, 1'b1, 1'b1},  // R1 broadcast
    {3'b001, 48'h0000_005E_0001, 2'd1, 1'b1, 1'b1},  // R3 R4 hit
    {3'b001, 48'h0000_005E_0001, 2'd2, 1'b0, 1'b1},  // R4 every other bit set
    {3'b000, 48'h0000_005E_0001, 2'd3, 1'b0, 1'b1},  // R3 enable low
    {3'b001, 48'h3322_11CC_BB33, 2'd1, 1'b1, 1'b1},  // R4 second index
    {3'b011, 48'h5544_3322_1102, 2'd0, 1'b1, 1'b0},  // R5 enables irrelevant
    {3'b010, 48'h0000_005E_0001, 2'd3, 1'b0, 1'b1},  // R3 bcast enable no help
    {3'b001, 48'h5544_3322_1102, 2'd3, 1'b1, 1'b0},  // R5 with full table
    {3'b001, 48'h5544_3322_1103, 2'd3, 1'b1, 1'b1}   // R3 station-like multicast
  };

  // Bench model of the hash index: 48 address bits, byte 0 bit 0 first.
  function automatic logic [5:0] refIndex(input logic [47:0] d);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int n = 0; n < 48; n++) begin
      logic fb = c[31] ^ d[n];
      c = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h04C1_1DB7;
    end
    return c[31:26];
  endfunction

  function automatic logic [63:0] buildTable(input logic [47:0] d, input logic [1:0] mode);
    logic [63:0] one = 64'd1 << refIndex(d);
    case (mode)
      2'd0: return 64'h0;
      2'd1: return one;
      2'd2: return ~one;
      default: return {64{1'b1}};
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendFrame(input logic [47:0] d);
    @(negedge clk); frameStart = 1'b1;
    @(negedge clk); frameStart = 1'b0;
    for (int k = 0; k < 6; k++) begin
      byteValid = 1'b1; byteData = d[8*k +: 8];
      @(negedge clk);
    end
    byteValid = 1'b0;
  endtask

  task automatic finish();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL R7 watchdog actual=running expected=done");
      finish();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 valid", {7'd0, decisionValid}, 8'd0);
    check("R10 accept/reject/group", {5'd0, accept, reject, groupAddr}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      logic [54:0] e = VEC[v];
      acceptAll   = e[54];
      acceptBcast = e[53];
      acceptMcast = e[52];
      hashTable   = buildTable(e[51:4], e[3:2]);
      sendFrame(e[51:4]);
      check($sformatf("R7 vec%0d valid", v), {7'd0, decisionValid}, 8'd1);
      check($sformatf("R1/R2/R3/R4/R5/R6 vec%0d accept,reject", v),
            {6'd0, accept, reject}, {6'd0, e[1], !e[1]});
      check($sformatf("R11 vec%0d group", v), {7'd0, groupAddr}, {7'd0, e[0]});
    end

    // R7 timing with a gap: not valid after five bytes, valid after the sixth
    acceptAll = 1'b0; acceptBcast = 1'b0; acceptMcast = 1'b0; hashTable = 64'h0;
    @(negedge clk); frameStart = 1'b1;
    @(negedge clk); frameStart = 1'b0;
    check("R9 cleared after start", {7'd0, decisionValid}, 8'd0);
    for (int k = 0; k < 5; k++) begin
      byteValid = 1'b1; byteData = stationAddr[8*k +: 8];
      @(negedge clk);
      if (k == 2) begin byteValid = 1'b0; @(negedge clk); end
    end
    byteValid = 1'b0;
    check("R7 not valid after five bytes", {7'd0, decisionValid}, 8'd0);
    @(negedge clk);
    check("R7 still waiting", {7'd0, decisionValid}, 8'd0);
    byteValid = 1'b1; byteData = stationAddr[47:40];
    @(negedge clk);
    byteValid = 1'b0;
    check("R7 valid after sixth byte", {6'd0, decisionValid, accept}, 8'd3);

    // R8 extra bytes and mode changes leave the verdict alone
    acceptAll = 1'b1; acceptMcast = 1'b1; hashTable = {64{1'b1}};
    for (int k = 0; k < 3; k++) begin
      byteValid = 1'b1; byteData = 8'hFF;
      @(negedge clk);
    end
    byteValid = 1'b0;
    check("R8 held verdict", {5'd0, decisionValid, accept, groupAddr}, 8'b110);

    // R6 silent reject of a foreign unicast
    acceptAll = 1'b0; acceptMcast = 1'b0;
    sendFrame(48'h0A0B_0C0D_0E10);
    check("R6 reject only", {5'd0, decisionValid, accept, reject}, 8'b101);

    // R9 byte alongside frameStart is not counted
    @(negedge clk); frameStart = 1'b1; byteValid = 1'b1; byteData = 8'h02;
    @(negedge clk); frameStart = 1'b0;
    check("R9 valid dropped", {7'd0, decisionValid}, 8'd0);
    for (int k = 0; k < 6; k++) begin
      byteValid = 1'b1; byteData = stationAddr[8*k +: 8];
      @(negedge clk);
    end
    byteValid = 1'b0;
    check("R9 overlapping byte ignored", {5'd0, decisionValid, accept, reject}, 8'b110);

    finish();
  end

endmodule